// File: doc/BRIEF.md
# TIS Command Transmit Sequencer

This block pushes one TPM command, held in an external byte buffer, into a TPM device by running the status/FIFO handshake of the TPM interface specification. It does not form serial frames itself. Each register access goes out as a one-byte transaction to a frame engine, which answers with a completion pulse and, for reads, the byte it read. The command buffer is read through a combinational byte-address port.

A start pulse with a command length begins the sequence. The block first claims locality 0 and then brings the device into the command-ready state. It then streams every byte except the last in chunks sized by the device's 16-bit burst count. The final byte is checked on both sides through the data-expect flag and written on its own, and the GO bit follows it. Every failure after the length check cancels the command and gives up the locality. The block then ends with a done pulse that carries an error code.

Top module: `tis_cmd_sender`

## Requirements
- R1: A start with a length below 10 bytes is refused. Done is high in the cycle after start is sampled, with err = 3 (too short), and no register access is issued.
- R2: Locality is claimed by writing 0x02 to register 0x00. Register 0x00 is then read repeatedly until a read returns both bit 0x80 and bit 0x20 set.
- R3: When a locality poll fails and at least TMO_A cycles have passed since the claim write completed, the command ends with err = 1 (timeout).
- R4: Register 0x18 is read once. If bit 0x40 is clear, 0x40 is written to 0x18 and 0x18 is polled until bit 0x40 is set. Giving up after TMO_B cycles gives err = 1.
- R5: Before every chunk the burst count is read: low byte from 0x19, then high byte from 0x1A. A zero value is read again, and giving up after TMO_D cycles gives err = 1.
- R6: Bytes 0 to len-2 are written to 0x24 in address order. Each chunk is min(burst count, len-1 minus bytes already sent), and chunk_end is high on the last byte of each chunk.
- R7: After the chunks, 0x18 is read. If bit 0x08 is clear, the command fails with err = 2 (I/O).
- R8: Byte len-1 is then written alone to 0x24 with chunk_end high, and 0x18 is read again. If bit 0x08 is still set, the command fails with err = 2.
- R9: On success, 0x20 is written to 0x18 and the command ends with err = 0.
- R10: Every failure except R1 writes 0x40 to 0x18 and then 0x20 to 0x00 before done.
- R11: Only one access is outstanding at a time, and xact_req is a single-cycle pulse. Done comes one cycle after the completion of the last access, while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin sending a command (ignored while busy) |
| cmd_len | input | LEN_W | Command length in bytes |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 2 | 0 none, 1 timeout, 2 I/O, 3 too short; valid with done |
| buf_addr | output | LEN_W | Command buffer byte address |
| buf_data | input | 8 | Command buffer byte at buf_addr |
| xact_req | output | 1 | One-cycle request for a register access |
| xact_wr | output | 1 | Access is a write |
| xact_addr | output | 8 | Register address |
| xact_wdata | output | 8 | Write byte |
| xact_chunk_end | output | 1 | Byte closes a FIFO chunk |
| xact_done | input | 1 | Access completed |
| xact_rdata | input | 8 | Read byte, valid with xact_done |

## Verification
A too-short command must raise done in the first cycle after start is sampled. Every other command must raise done exactly one cycle after the frame engine's completion pulse for its final access. The bench notes the cycle of each completion it gives and samples done on the falling edge, so both timings are checked exactly. Register accesses are not tied to cycles: they are compared in order against the expected sequence as each request appears. Timeouts are checked only for a lower bound on elapsed cycles, because the number of polls depends on the response latency.

// File: rtl/tis_tx_pkg.sv
// Package: shared codes for the TIS command transmit sequencer.
// Holds the register addresses, bit masks, error codes and FSM states.
package tis_tx_pkg;
    typedef enum logic [1:0] {
        TX_OK      = 2'd0,
        TX_TIMEOUT = 2'd1,
        TX_IOERR   = 2'd2,
        TX_SHORT   = 2'd3
    } tx_err_e;

    typedef enum logic [3:0] {
        S_IDLE, S_LOC_REQ, S_LOC_POLL, S_STS_CHK, S_STS_CXL, S_STS_POLL,
        S_BC_LO, S_BC_HI, S_FIFO, S_PRE_LAST, S_LAST, S_POST_LAST,
        S_GO, S_AB_CXL, S_AB_REL
    } seq_state_e;

    localparam logic [7:0] REG_ACCESS   = 8'h00;
    localparam logic [7:0] REG_STATUS   = 8'h18;
    localparam logic [7:0] REG_BURST_LO = 8'h19;
    localparam logic [7:0] REG_BURST_HI = 8'h1A;
    localparam logic [7:0] REG_FIFO     = 8'h24;

    localparam logic [7:0] ACC_REQ_USE  = 8'h02;
    localparam logic [7:0] ACC_ACTIVE   = 8'h20;
    localparam logic [7:0] ACC_VALID    = 8'h80;

    localparam logic [7:0] STS_CMD_RDY  = 8'h40;
    localparam logic [7:0] STS_GO       = 8'h20;
    localparam logic [7:0] STS_DATA_EXP = 8'h08;
endpackage

// File: rtl/tis_wait_timer.sv
// Module: tis_wait_timer
// Counts clock cycles from the last clear and saturates at the limit.
// Assumes the limit is stable while the poll phase using it runs.
module tis_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // Cycle counter, restarted by clr, holds once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (cnt < limit) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= limit);
endmodule

// File: rtl/tis_chunk_size.sv
// Module: tis_chunk_size
// Picks the next FIFO chunk size as the smaller of burst count and remainder.
// Assumes remain excludes the held-back final byte.
module tis_chunk_size #(
    parameter int LEN_W = 12
) (
    input  logic [15:0]      burst,
    input  logic [LEN_W-1:0] remain,
    output logic [LEN_W-1:0] chunk
);
    localparam int MW = (LEN_W > 16) ? LEN_W : 16;

    logic [MW-1:0] b_ext;
    logic [MW-1:0] r_ext;

    // Widen both operands to a common width before comparing.
    always_comb begin
        b_ext = MW'(burst);
        r_ext = MW'(remain);
        chunk = (b_ext < r_ext) ? b_ext[LEN_W-1:0] : remain;
    end
endmodule

// File: rtl/tis_cmd_sender.sv
// Module: tis_cmd_sender
// Sends one command through the TIS status/FIFO handshake: claim locality,
// ensure command-ready, stream chunks by burst count, hold back and check
// the final byte, issue GO. Failures cancel and release the locality.
// Assumes buf_data is combinational from buf_addr and that xact_done comes
// at least one cycle after xact_req.
module tis_cmd_sender
    import tis_tx_pkg::*;
#(
    parameter int LEN_W   = 12,
    parameter int HDR_LEN = 10,
    parameter int TMO_A   = 2000,
    parameter int TMO_B   = 20000,
    parameter int TMO_D   = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cmd_len,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err,
    output logic [LEN_W-1:0] buf_addr,
    input  logic [7:0]       buf_data,
    output logic             xact_req,
    output logic             xact_wr,
    output logic [7:0]       xact_addr,
    output logic [7:0]       xact_wdata,
    output logic             xact_chunk_end,
    input  logic             xact_done,
    input  logic [7:0]       xact_rdata
);
    localparam int TMO_AB  = (TMO_A > TMO_B) ? TMO_A : TMO_B;
    localparam int TMO_MAX = (TMO_AB > TMO_D) ? TMO_AB : TMO_D;
    localparam int CW      = $clog2(TMO_MAX + 1) + 1;
    localparam logic [CW-1:0]    LIM_A = CW'(TMO_A);
    localparam logic [CW-1:0]    LIM_B = CW'(TMO_B);
    localparam logic [CW-1:0]    LIM_D = CW'(TMO_D);
    localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
    localparam logic [LEN_W-1:0] HDR_W = LEN_W'(HDR_LEN);

    seq_state_e       state;
    tx_err_e          err_q;
    logic             pend;
    logic             done_q;
    logic             tmo_clr;
    logic             tmo_exp;
    logic [CW-1:0]    tmo_lim;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] chunk_left;
    logic [LEN_W-1:0] chunk_new;
    logic [7:0]       bc_lo;
    logic [15:0]      burst_now;
    logic             is_bus;
    logic             fin;

    assign fin       = pend && xact_done;
    assign burst_now = {xact_rdata, bc_lo};
    assign busy      = (state != S_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign buf_addr  = idx;
    assign xact_req  = is_bus && !pend;

    // Timeout limit belongs to the poll phase in progress.
    always_comb begin
        case (state)
            S_LOC_POLL: tmo_lim = LIM_A;
            S_STS_POLL: tmo_lim = LIM_B;
            default:    tmo_lim = LIM_D;
        endcase
    end

    tis_wait_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmo_clr),
        .limit   (tmo_lim),
        .expired (tmo_exp)
    );

    tis_chunk_size #(.LEN_W(LEN_W)) u_chunk (
        .burst  (burst_now),
        .remain (len_q - ONE - idx),
        .chunk  (chunk_new)
    );

    // Register access issued by the current state.
    always_comb begin
        is_bus         = 1'b1;
        xact_wr        = 1'b0;
        xact_addr      = REG_STATUS;
        xact_wdata     = 8'h00;
        xact_chunk_end = 1'b0;
        case (state)
            S_LOC_REQ:  begin xact_wr = 1'b1; xact_addr = REG_ACCESS; xact_wdata = ACC_REQ_USE; end
            S_LOC_POLL: xact_addr = REG_ACCESS;
            S_STS_CHK, S_STS_POLL, S_PRE_LAST, S_POST_LAST: xact_addr = REG_STATUS;
            S_STS_CXL, S_AB_CXL: begin xact_wr = 1'b1; xact_wdata = STS_CMD_RDY; end
            S_BC_LO:    xact_addr = REG_BURST_LO;
            S_BC_HI:    xact_addr = REG_BURST_HI;
            S_FIFO:     begin
                xact_wr = 1'b1; xact_addr = REG_FIFO; xact_wdata = buf_data;
                xact_chunk_end = (chunk_left == ONE);
            end
            S_LAST:     begin
                xact_wr = 1'b1; xact_addr = REG_FIFO; xact_wdata = buf_data;
                xact_chunk_end = 1'b1;
            end
            S_GO:       begin xact_wr = 1'b1; xact_wdata = STS_GO; end
            S_AB_REL:   begin xact_wr = 1'b1; xact_addr = REG_ACCESS; xact_wdata = ACC_ACTIVE; end
            default:    is_bus = 1'b0;
        endcase
    end

    // Sequencer: advances on each access completion and tracks byte position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            err_q      <= TX_OK;
            pend       <= 1'b0;
            done_q     <= 1'b0;
            tmo_clr    <= 1'b0;
            len_q      <= '0;
            idx        <= '0;
            chunk_left <= '0;
            bc_lo      <= 8'h00;
        end else begin
            done_q  <= 1'b0;
            tmo_clr <= 1'b0;
            if (xact_req) pend <= 1'b1;
            if (fin)      pend <= 1'b0;
            if (state == S_IDLE) begin
                if (start) begin
                    len_q <= cmd_len;
                    idx   <= '0;
                    if (cmd_len < HDR_W) begin
                        done_q <= 1'b1;
                        err_q  <= TX_SHORT;
                    end else begin
                        err_q <= TX_OK;
                        state <= S_LOC_REQ;
                    end
                end
            end else if (fin) begin
                case (state)
                    S_LOC_REQ: begin state <= S_LOC_POLL; tmo_clr <= 1'b1; end
                    S_LOC_POLL: begin
                        if ((xact_rdata & (ACC_ACTIVE | ACC_VALID)) == (ACC_ACTIVE | ACC_VALID))
                            state <= S_STS_CHK;
                        else if (tmo_exp) begin state <= S_AB_CXL; err_q <= TX_TIMEOUT; end
                    end
                    S_STS_CHK: begin
                        if ((xact_rdata & STS_CMD_RDY) != 8'h00) begin state <= S_BC_LO; tmo_clr <= 1'b1; end
                        else state <= S_STS_CXL;
                    end
                    S_STS_CXL: begin state <= S_STS_POLL; tmo_clr <= 1'b1; end
                    S_STS_POLL: begin
                        if ((xact_rdata & STS_CMD_RDY) != 8'h00) begin state <= S_BC_LO; tmo_clr <= 1'b1; end
                        else if (tmo_exp) begin state <= S_AB_CXL; err_q <= TX_TIMEOUT; end
                    end
                    S_BC_LO: begin bc_lo <= xact_rdata; state <= S_BC_HI; end
                    S_BC_HI: begin
                        if (burst_now != 16'h0000) begin chunk_left <= chunk_new; state <= S_FIFO; end
                        else if (tmo_exp) begin state <= S_AB_CXL; err_q <= TX_TIMEOUT; end
                        else state <= S_BC_LO;
                    end
                    S_FIFO: begin
                        idx        <= idx + ONE;
                        chunk_left <= chunk_left - ONE;
                        if (chunk_left == ONE) begin
                            if (idx + ONE == len_q - ONE) state <= S_PRE_LAST;
                            else begin state <= S_BC_LO; tmo_clr <= 1'b1; end
                        end
                    end
                    S_PRE_LAST: begin
                        if ((xact_rdata & STS_DATA_EXP) != 8'h00) state <= S_LAST;
                        else begin state <= S_AB_CXL; err_q <= TX_IOERR; end
                    end
                    S_LAST: state <= S_POST_LAST;
                    S_POST_LAST: begin
                        if ((xact_rdata & STS_DATA_EXP) == 8'h00) state <= S_GO;
                        else begin state <= S_AB_CXL; err_q <= TX_IOERR; end
                    end
                    S_GO:     begin state <= S_IDLE; done_q <= 1'b1; end
                    S_AB_CXL: state <= S_AB_REL;
                    S_AB_REL: begin state <= S_IDLE; done_q <= 1'b1; end
                    default:  state <= S_IDLE;
                endcase
            end
        end
    end

    // A request is never repeated before its completion.
    p_req_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        xact_req |=> !xact_req);

    // Done is reported from idle with no access pending.
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !xact_req));

    // Short commands end at once with the short code.
    p_short_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (cmd_len < HDR_W)) |=> (done && err == TX_SHORT));

    // A FIFO chunk state always has bytes left to send.
    p_chunk_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FIFO) |-> (chunk_left != '0));

    // Release is only reached through the cancel write.
    p_release_after_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AB_REL) |-> ($past(state) == S_AB_CXL || $past(state) == S_AB_REL));
endmodule

// File: tb/tis_cmd_sender_bench.sv
// Bench: scoreboard of expected register accesses against a device model.
module tis_cmd_sender_bench;
    localparam int LW = 12;
    localparam int TA = 30;
    localparam int TB = 40;
    localparam int TD = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] cmd_len = '0;
    logic          busy, done;
    logic [1:0]    err;
    logic [LW-1:0] buf_addr;
    logic [7:0]    buf_data;
    logic          xact_req, xact_wr, xact_chunk_end;
    logic [7:0]    xact_addr, xact_wdata;
    logic          xact_done = 1'b0;
    logic [7:0]    xact_rdata = 8'h00;

    always #10 clk = ~clk;

    tis_cmd_sender #(.LEN_W(LW), .TMO_A(TA), .TMO_B(TB), .TMO_D(TD)) u_tis_cmd_sender (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len),
        .busy(busy), .done(done), .err(err),
        .buf_addr(buf_addr), .buf_data(buf_data),
        .xact_req(xact_req), .xact_wr(xact_wr), .xact_addr(xact_addr),
        .xact_wdata(xact_wdata), .xact_chunk_end(xact_chunk_end),
        .xact_done(xact_done), .xact_rdata(xact_rdata)
    );

    function automatic logic [7:0] byte_at(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction
    assign buf_data = byte_at(int'(buf_addr));

    typedef struct {
        bit       wr;
        bit [7:0] addr;
        bit [7:0] data;
        bit       ce;
        bit       rep;
        string    tag;
    } item_t;
    item_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc++;

    // Device model configuration and state.
    int grant, acc_polls, cr_after, cr_polls, zero_left, dmode, fifo_cnt, dev_len, pend_cnt, done_at;
    bit cr;
    bit [15:0] bval;
    bit [7:0]  resp;

    task automatic push(bit wr, bit [7:0] a, bit [7:0] d, bit ce, bit rep, string tag);
        item_t it;
        it.wr = wr; it.addr = a; it.data = d; it.ce = ce; it.rep = rep; it.tag = tag;
        exp_q.push_back(it);
    endtask

    function automatic bit match(item_t e);
        if (e.wr != xact_wr || e.addr != xact_addr) return 1'b0;
        if (!e.wr) return 1'b1;
        if (e.data != xact_wdata) return 1'b0;
        return (e.addr != 8'h24) || (e.ce == xact_chunk_end);
    endfunction

    task automatic dev_access();
        resp = 8'h00;
        if (xact_wr) begin
            if (xact_addr == 8'h00 && xact_wdata == 8'h02) acc_polls = 0;
            if (xact_addr == 8'h18 && xact_wdata == 8'h40 && !cr) cr_polls = 0;
            if (xact_addr == 8'h24) fifo_cnt++;
        end else if (xact_addr == 8'h00) begin
            acc_polls++;
            resp = (grant >= 0 && acc_polls >= grant) ? 8'hA0 : 8'h80;
        end else if (xact_addr == 8'h18) begin
            if (!cr && cr_after >= 0) begin
                cr_polls++;
                if (cr_polls >= cr_after) cr = 1'b1;
            end
            resp = 8'h80 | (cr ? 8'h40 : 8'h00);
            if ((dmode == 0 && fifo_cnt < dev_len) || dmode == 2) resp = resp | 8'h08;
        end else if (xact_addr == 8'h19) begin
            resp = (zero_left != 0) ? 8'h00 : bval[7:0];
        end else if (xact_addr == 8'h1A) begin
            if (zero_left != 0) begin
                resp = 8'h00;
                if (zero_left > 0) zero_left--;
            end else resp = bval[15:8];
        end
    endtask

    // Device model: completes each access two cycles after its request.
    always @(negedge clk) begin
        xact_done = 1'b0;
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
                xact_done = 1'b1;
                xact_rdata = resp;
                done_at = cyc;
            end
        end
        if (rst_n && xact_req) begin
            dev_access();
            pend_cnt = 2;
        end
    end

    // Monitor: compares each issued access against the expected queue.
    always @(negedge clk) begin : mon
        bit    going;
        item_t h;
        if (rst_n && xact_req) begin
            going = 1'b1;
            while (going) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R11: unexpected access wr=%0d addr=%h data=%h, expected none",
                             xact_wr, xact_addr, xact_wdata);
                    going = 1'b0;
                end else if (match(exp_q[0])) begin
                    checks++;
                    if (!exp_q[0].rep) void'(exp_q.pop_front());
                    going = 1'b0;
                end else if (exp_q[0].rep && exp_q.size() > 1 && exp_q[1].rep && match(exp_q[1])) begin
                    h = exp_q.pop_front();
                    exp_q.insert(1, h);
                end else if (exp_q[0].rep) begin
                    void'(exp_q.pop_front());
                end else begin
                    checks++; errors++;
                    $display("FAIL %s: got wr=%0d addr=%h data=%h ce=%0d, expected wr=%0d addr=%h data=%h ce=%0d",
                             exp_q[0].tag, xact_wr, xact_addr, xact_wdata, xact_chunk_end,
                             exp_q[0].wr, exp_q[0].addr, exp_q[0].data, exp_q[0].ce);
                    void'(exp_q.pop_front());
                    going = 1'b0;
                end
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Driver: builds the expected access list, starts the command, checks the end.
    task automatic run(int len, int g, bit cri, int cra, int zeros, int bv, int mode,
                       int exp_err, string tag, int min_cyc);
        bit ab;
        int idx, c, z, t0, n;
        grant = g; acc_polls = 0; cr = cri; cr_after = cra; cr_polls = 0;
        zero_left = zeros; bval = 16'(bv); dmode = mode; fifo_cnt = 0; dev_len = len;
        ab = 1'b0;
        if (len >= 10) begin
            push(1, 8'h00, 8'h02, 0, 0, "R2");
            if (g < 0) begin push(0, 8'h00, 8'h00, 0, 1, "R3"); ab = 1'b1; end
            else for (int i = 0; i < g; i++) push(0, 8'h00, 8'h00, 0, 0, "R2");
            if (!ab) begin
                push(0, 8'h18, 8'h00, 0, 0, "R4");
                if (!cri) begin
                    push(1, 8'h18, 8'h40, 0, 0, "R4");
                    if (cra < 0) begin push(0, 8'h18, 8'h00, 0, 1, "R4"); ab = 1'b1; end
                    else for (int i = 0; i < cra; i++) push(0, 8'h18, 8'h00, 0, 0, "R4");
                end
            end
            if (!ab) begin
                idx = 0; z = zeros;
                while (idx < len - 1 && !ab) begin
                    if (z < 0) begin
                        push(0, 8'h19, 8'h00, 0, 1, "R5");
                        push(0, 8'h1A, 8'h00, 0, 1, "R5");
                        ab = 1'b1;
                    end else begin
                        for (int i = 0; i < z; i++) begin
                            push(0, 8'h19, 8'h00, 0, 0, "R5");
                            push(0, 8'h1A, 8'h00, 0, 0, "R5");
                        end
                        z = 0;
                        push(0, 8'h19, 8'h00, 0, 0, "R5");
                        push(0, 8'h1A, 8'h00, 0, 0, "R5");
                        c = (bv < len - 1 - idx) ? bv : len - 1 - idx;
                        for (int k = 0; k < c; k++)
                            push(1, 8'h24, byte_at(idx + k), (k == c - 1), 0, "R6");
                        idx += c;
                    end
                end
            end
            if (!ab) begin
                push(0, 8'h18, 8'h00, 0, 0, "R7");
                if (mode == 1) ab = 1'b1;
                else begin
                    push(1, 8'h24, byte_at(len - 1), 1, 0, "R8");
                    push(0, 8'h18, 8'h00, 0, 0, "R8");
                    if (mode == 2) ab = 1'b1;
                    else push(1, 8'h18, 8'h20, 0, 0, "R9");
                end
            end
            if (ab) begin
                push(1, 8'h18, 8'h40, 0, 0, "R10");
                push(1, 8'h00, 8'h20, 0, 0, "R10");
            end
        end
        @(negedge clk);
        start = 1'b1; cmd_len = LW'(len); t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        check(done == 1'b1, {tag, " done seen (R11)"}, n, 0);
        check(int'(err) == exp_err, {tag, " error code"}, int'(err), exp_err);
        if (len < 10) check(n == 0, "R1 done one cycle after start", n, 0);
        else check(cyc == done_at + 1, "R11 done one cycle after last completion", cyc, done_at + 1);
        if (min_cyc > 0) check(cyc - t0 >= min_cyc, {tag, " timeout not early"}, cyc - t0, min_cyc);
        check(exp_q.size() == 0, {tag, " accesses left unissued"}, exp_q.size(), 0);
        exp_q.delete();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        pend_cnt = 0; done_at = 0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !xact_req, "R11 reset state", int'(busy) + int'(done) + int'(xact_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run(9,  2, 1, 0, 0, 5, 0, 3, "R1", 0);
        run(0,  2, 1, 0, 0, 5, 0, 3, "R1", 0);
        run(12, 2, 1, 0, 0, 5, 0, 0, "R9", 0);
        run(15, 1, 0, 3, 2, 4, 0, 0, "R4", 0);
        run(20, 1, 1, 0, 0, 16'h0100, 0, 0, "R5", 0);
        run(10, 1, 1, 0, 0, 1, 0, 0, "R6", 0);
        run(12, -1, 1, 0, 0, 5, 0, 1, "R3", TA);
        run(12, 1, 0, -1, 0, 5, 0, 1, "R4", TB);
        run(12, 1, 1, 0, -1, 5, 0, 1, "R5", TD);
        run(14, 1, 1, 0, 0, 6, 1, 2, "R7", 0);
        run(14, 1, 1, 0, 0, 6, 2, 2, "R8", 0);
        run(11, 3, 1, 0, 1, 3, 0, 0, "R10", 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R11: watchdog expired, actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule